// File: doc/BRIEF.md
# Masked Address Match Detector

This block watches an 8-bit bus address and signals, through an active-low output, when the address matches a programmed pattern on every bit that a mask enables. Two configuration registers are loaded from a local data bus: a pattern register and a mask register. A write happens on the rising edge of a strobe. A select line chooses the target register, and an active-low transfer line blocks all writes while it is low. A pattern write also clears the mask. As a result, the match output cannot fire partway through configuration until a fresh mask has been loaded.

A small four-state sequencer records how far configuration has progressed since reset. The states are BLANK (nothing written), PAT (pattern written and mask cleared), MASK (mask written with no pattern) and LIVE (pattern, then mask, written). The transitions are:
- From BLANK, a pattern write goes to PAT and a mask write goes to MASK.
- From MASK, a pattern write goes to PAT.
- From PAT, a mask write goes to LIVE.
- From LIVE, a pattern write returns to PAT, because it clears the mask.
- A mask write in MASK or LIVE keeps the current state.

The match output can go low only in LIVE, only with a nonzero mask, and it is registered.

Top module: `masked_addr_cmp`

## Requirements
- R1: After reset, hit_n_o is 1 and the sequencer is in BLANK.
- R2: A rising edge of stb_i, seen at a clock edge while xfer_n_i=1 and pick_pat_i=1, loads cfg_data_i into the pattern register.
- R3: A rising edge of stb_i, seen at a clock edge while xfer_n_i=1 and pick_pat_i=0, loads cfg_data_i into the mask register.
- R4: Every pattern write sets the mask register to all zeros in the same clock, so hit_n_o stays 1 until a new mask is written.
- R5: While xfer_n_i=0, a strobe edge changes neither register.
- R6: Mask bit i=1 makes address bit i take part in the comparison, and mask bit i=0 ignores it. hit_n_o=0 when every enabled bit of addr_i equals the pattern bit.
- R7: While the mask register is all zeros, hit_n_o is 1 for any address.
- R8: hit_n_o stays 1 until a pattern write and then a mask write have both occurred since reset. A mask write alone is not enough.
- R9: Only the low-to-high transition of stb_i writes. Holding stb_i high while cfg_data_i changes causes no further write.
- R10: hit_n_o is registered. It reflects addr_i and the register contents one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Configuration strobe; its rising edge writes |
| pick_pat_i | input | 1 | 1 selects the pattern register, 0 selects the mask register |
| xfer_n_i | input | 1 | Active-low transfer indication; writes are blocked while it is 0 |
| cfg_data_i | input | 8 | Local data written into the selected register |
| addr_i | input | 8 | Bus address under comparison |
| hit_n_o | output | 1 | Registered active-low match |

## Verification
The assertions assume that stb_i, pick_pat_i, xfer_n_i and cfg_data_i are synchronous to clk and settle before the edge at which the strobe is sampled. They also assume that the select and data lines hold steady across that edge. The bench drives every input on the falling clock edge and keeps each strobe pulse high for one full clock. In that way, each strobe rise is seen at exactly one rising edge, with stable select and data.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;
    typedef enum logic [1:0] {
        CS_BLANK = 2'd0,
        CS_PAT   = 2'd1,
        CS_MASK  = 2'd2,
        CS_LIVE  = 2'd3
    } cmp_state_t;
endpackage

// File: rtl/amc_edge.sv
`timescale 1ns/1ps
module amc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    output logic rise_o
);
    logic stb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_i;
    end

    assign rise_o = stb_i & ~stb_q;

    // R9: a rise cannot be reported on two consecutive clocks
    p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("p_single_rise_r9");
endmodule

// File: rtl/amc_regs.sv
`timescale 1ns/1ps
module amc_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         pick_pat_i,
    input  logic         xfer_n_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] pat_o,
    output logic [W-1:0] mask_o,
    output logic         wr_pat_o,
    output logic         wr_mask_o
);
    assign wr_pat_o  = rise_i & xfer_n_i &  pick_pat_i;
    assign wr_mask_o = rise_i & xfer_n_i & ~pick_pat_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_o <= '0;
        else if (wr_pat_o) pat_o <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_o <= '0;
        else if (wr_pat_o) mask_o <= '0;
        else if (wr_mask_o) mask_o <= din_i;
    end

    // R4: a pattern write leaves the mask empty
    p_pat_clears_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pat_o |=> (mask_o == '0))
        else $error("p_pat_clears_mask_r4");

    // R5: transfer low freezes both registers
    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_n_i |=> ($stable(pat_o) && $stable(mask_o)))
        else $error("p_blocked_r5");
endmodule

// File: rtl/amc_fsm.sv
`timescale 1ns/1ps
module amc_fsm
    import amc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_pat_i,
    input  logic       wr_mask_i,
    output cmp_state_t state_o,
    output logic       live_o
);
    cmp_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_BLANK: if (wr_pat_i) state_d = CS_PAT;
                      else if (wr_mask_i) state_d = CS_MASK;
            CS_PAT:   if (wr_mask_i) state_d = CS_LIVE;
            CS_MASK:  if (wr_pat_i) state_d = CS_PAT;
            CS_LIVE:  if (wr_pat_i) state_d = CS_PAT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_BLANK;
        else        state_q <= state_d;
    end

    always_comb begin
        live_o  = 1'b0;
        state_o = state_q;
        unique case (state_q)
            CS_BLANK, CS_PAT, CS_MASK: live_o = 1'b0;
            CS_LIVE:                   live_o = 1'b1;
        endcase
    end

    // R8: any pattern write lands the sequencer in PAT
    p_pat_to_pat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pat_i |=> (state_q == CS_PAT))
        else $error("p_pat_to_pat_r8");
endmodule

// File: rtl/amc_match.sv
`timescale 1ns/1ps
module amc_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] pat_i,
    input  logic [W-1:0] mask_i,
    output logic         eq_o
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = ~mask_i[i] | ~(addr_i[i] ^ pat_i[i]);
    end

    assign eq_o = &bit_ok;
endmodule

// File: rtl/masked_addr_cmp.sv
`timescale 1ns/1ps
module masked_addr_cmp
    import amc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic         pick_pat_i,
    input  logic         xfer_n_i,
    input  logic [W-1:0] cfg_data_i,
    input  logic [W-1:0] addr_i,
    output logic         hit_n_o
);
    logic         rise, wr_pat, wr_mask, live, eq;
    logic [W-1:0] pat, mask;
    cmp_state_t   state;

    amc_edge u_edge (.clk(clk), .rst_n(rst_n), .stb_i(stb_i), .rise_o(rise));

    amc_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .pick_pat_i(pick_pat_i),
        .xfer_n_i(xfer_n_i), .din_i(cfg_data_i), .pat_o(pat), .mask_o(mask),
        .wr_pat_o(wr_pat), .wr_mask_o(wr_mask)
    );

    amc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_pat_i(wr_pat), .wr_mask_i(wr_mask),
        .state_o(state), .live_o(live)
    );

    amc_match #(.W(W)) u_match (.addr_i(addr_i), .pat_i(pat), .mask_i(mask), .eq_o(eq));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_n_o <= 1'b1;
        else        hit_n_o <= ~(live & (|mask) & eq);
    end

    // R7: an empty mask never yields a match
    p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> hit_n_o)
        else $error("p_zero_mask_r7");

    // R8: no match outside the LIVE state
    p_not_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CS_LIVE) |=> hit_n_o)
        else $error("p_not_live_r8");

    // R10: a live, fully matching address is reported one clock later
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_LIVE) && (mask != '0) && (((addr_i ^ pat) & mask) == '0)) |=> !hit_n_o)
        else $error("p_latency_r10");
endmodule

// File: tb/sim_masked_addr_cmp.sv
`timescale 1ns/1ps
module sim_masked_addr_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_i = 1'b0;
    logic       pick_pat_i = 1'b0;
    logic       xfer_n_i = 1'b1;
    logic [7:0] cfg_data_i = 8'h00;
    logic [7:0] addr_i = 8'h00;
    logic       hit_n_o;
    int         n_chk = 0;
    int         n_err = 0;

    masked_addr_cmp u0 (.clk(clk), .rst_n(rst_n), .stb_i(stb_i), .pick_pat_i(pick_pat_i),
        .xfer_n_i(xfer_n_i), .cfg_data_i(cfg_data_i), .addr_i(addr_i), .hit_n_o(hit_n_o));

    always #2 clk = ~clk;

    task automatic chk(input logic exp, input string req);
        n_chk++;
        if (hit_n_o !== exp) begin
            n_err++;
            $display("FAIL %s: hit_n_o=%b expected %b", req, hit_n_o, exp);
        end
    endtask

    task automatic wr(input logic pat, input logic [7:0] d, input logic xn);
        @(negedge clk);
        pick_pat_i = pat; cfg_data_i = d; xfer_n_i = xn; stb_i = 1'b1;
        @(negedge clk);
        stb_i = 1'b0;
        @(negedge clk);
        xfer_n_i = 1'b1;
    endtask

    task automatic put_addr(input logic [7:0] a);
        @(negedge clk);
        addr_i = a;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(1'b1, "R1 reset");
        put_addr(8'h00);
        chk(1'b1, "R1 reset idle");
    endtask

    task automatic t_mask_only;
        wr(1'b0, 8'hFF, 1'b1);
        put_addr(8'h00);
        chk(1'b1, "R8 mask only");
    endtask

    task automatic t_basic;
        wr(1'b1, 8'hA5, 1'b1);
        put_addr(8'hA5);
        chk(1'b1, "R8 pattern without mask");
        wr(1'b0, 8'hFF, 1'b1);
        chk(1'b0, "R2 R3 full match");
        put_addr(8'hA4);
        chk(1'b1, "R6 one bit differs");
        @(negedge clk); addr_i = 8'hA5;
        #1 chk(1'b1, "R10 old value before edge");
        @(negedge clk);
        chk(1'b0, "R10 new value after one clock");
    endtask

    task automatic t_partial;
        wr(1'b0, 8'hF0, 1'b1);
        put_addr(8'hA3);
        chk(1'b0, "R6 low nibble ignored");
        put_addr(8'h55);
        chk(1'b1, "R6 high nibble differs");
    endtask

    task automatic t_clear;
        wr(1'b1, 8'h3C, 1'b1);
        put_addr(8'h3C);
        chk(1'b1, "R4 mask cleared by pattern write");
        wr(1'b0, 8'hFF, 1'b1);
        chk(1'b0, "R4 match after new mask");
    endtask

    task automatic t_block;
        wr(1'b1, 8'h00, 1'b0);
        put_addr(8'h3C);
        chk(1'b0, "R5 blocked pattern write");
        wr(1'b0, 8'h00, 1'b0);
        chk(1'b0, "R5 blocked mask write");
    endtask

    task automatic t_level;
        @(negedge clk);
        pick_pat_i = 1'b0; cfg_data_i = 8'h0F; stb_i = 1'b1;
        @(negedge clk);
        cfg_data_i = 8'hFF;
        repeat (3) @(negedge clk);
        stb_i = 1'b0;
        put_addr(8'h30);
        chk(1'b1, "R9 first value kept, upper bits ignored");
        put_addr(8'h0C);
        chk(1'b0, "R9 low nibble match");
    endtask

    task automatic t_zero_mask;
        wr(1'b0, 8'h00, 1'b1);
        put_addr(8'h3C);
        chk(1'b1, "R7 zero mask");
        put_addr(8'h00);
        chk(1'b1, "R7 zero mask other address");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_only();
        t_basic();
        t_partial();
        t_clear();
        t_block();
        t_level();
        t_zero_mask();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule